// File: doc/BRIEF.md
# Handshaked Iterative Factorial Unit

This block computes the factorial of a small unsigned operand with a single multiplier. It steps through one multiply-and-decrement per loop pass. A requester presents an operand and raises `req`. The unit captures the operand and runs its loop. It then places the product on `result` and answers with a one-cycle `ack` pulse, after which it goes back to waiting.

The working registers are narrower than the ports:

- The down-counter keeps only the low four operand bits.
- The accumulator keeps 24 bits, so every product is reduced modulo 2^24.
- The wider result port is zero-extended from the accumulator.

Every control decision takes one clock cycle. This covers the request wait, the loop test and each branch taken. The latency therefore grows linearly with the captured count.

The synchronous active-low `rst_n` is the run enable. While it is low, the controller is held at the top of its loop with `ack` low.

Top module: `fact_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit goes to its idle entry state after that edge, with `ack` at 0 and `result` at 0. Requests made during that time are not acted upon.
- R2: While waiting, the unit stays idle as long as `req` is 0, and `ack` stays 0.
- R3: The result is the product k·(k−1)·…·2 reduced modulo 2^24, where k is `operand[3:0]`.
- R4: An operand whose low four bits are 0 or 1 produces a result of 1 with no multiply step.
- R5: `ack` rises a fixed number of rising edges after the edge that first sees `req` high in the waiting state, counting that edge. The count is 5 when k < 2 and 2k+3 otherwise.
- R6: `ack` is high for exactly one cycle and is low again before the next request can be accepted.
- R7: `result` keeps its last value until the next computation replaces it. This holds across idle cycles and during the early cycles of the next computation.
- R8: `result[31:24]` is always 0.
- R9: `operand[4]` has no effect on the result or on the latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; high lets the loop run |
| req | input | 1 | Request; sampled only while the unit waits |
| operand | input | 5 | Unsigned operand; only the low four bits are used |
| ack | output | 1 | One-cycle completion pulse |
| result | output | 32 | Truncated factorial, zero-extended |

## Verification
The bench covers the following corner cases:

- **Operands 0 and 1.** A design that enters the multiply loop on them would return 0 or take the wrong time.
- **Operands 11 to 15.** These wrap the 24-bit accumulator. A design that kept a wider product, or truncated it at the wrong width, would show wrong upper bits.
- **Operands with bit 4 set.** These expose a counter that is loaded with the full operand.
- **Handshake timing.** The bench counts the latency of each request exactly, so an extra or missing state shows up. It checks that `ack` falls after one cycle and that a held-low `req` never produces an answer.
- **Old result kept.** The bench checks that the previous result is still visible early in the next computation.
- **Reset.** A reset in the middle of a computation must clear both outputs.

// File: rtl/fact_pkg.sv
// Package: shared types and constants for the factorial unit.
// Assumes: nothing beyond IEEE 1800-2017.
package fact_pkg;

    // Controller states in loop order.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // top of loop: acknowledge dropped
        ST_WAIT = 3'd1,   // stall until request equals 1
        ST_LOAD = 3'd2,   // capture operand, seed accumulator
        ST_TEST = 3'd3,   // loop test: counter greater than 1?
        ST_MUL  = 3'd4,   // one multiply and one decrement
        ST_PUB  = 3'd5,   // copy accumulator to result
        ST_ACK  = 3'd6    // raise acknowledge
    } fact_state_e;

endpackage

// File: rtl/fact_ctrl.sv
// Module: fact_ctrl
// Purpose: sequences the factorial loop. Each state is one cycle, so every
//          wait test and loop test costs one clock per branch taken.
// Assumes: the datapath reports more_steps from its registered counter;
//          rst_n is synchronous and active low.
module fact_ctrl
    import fact_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic more_steps,
    output logic load_en,
    output logic mul_en,
    output logic pub_en,
    output logic ack
);

    fact_state_e state_q;
    fact_state_e state_d;
    logic        ack_q;

    // Next-state selection for the outer and inner loops.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: state_d = ST_WAIT;
            ST_WAIT: state_d = (req == 1'b1) ? ST_LOAD : ST_WAIT;
            ST_LOAD: state_d = ST_TEST;
            ST_TEST: state_d = more_steps ? ST_MUL : ST_PUB;
            ST_MUL:  state_d = ST_TEST;
            ST_PUB:  state_d = ST_ACK;
            ST_ACK:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and registered acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ACK) begin
                ack_q <= 1'b1;
            end else if (state_q == ST_IDLE) begin
                ack_q <= 1'b0;
            end
        end
    end

    // Strobes to the datapath.
    always_comb begin
        load_en = (state_q == ST_LOAD);
        mul_en  = (state_q == ST_MUL);
        pub_en  = (state_q == ST_PUB);
    end

    assign ack = ack_q;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_IDLE && !ack_q));                          // R1
    AST_HOLD_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && req != 1'b1) |=> (state_q == ST_WAIT && !ack_q)); // R2
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |=> !ack_q);                                                   // R6
    AST_ACK_FROM_ACK_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> $past(state_q) == ST_ACK);                          // R5
    AST_SMALL_SKIPS_MUL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TEST && !more_steps) |=> state_q == ST_PUB);          // R4

endmodule

// File: rtl/fact_datapath.sv
// Module: fact_datapath
// Purpose: holds the down-counter, the accumulator and the result register.
//          The counter takes the low CNTW operand bits; products are kept to
//          ACCW bits; the result is the zero-extended accumulator.
// Assumes: OPW >= CNTW and RESW >= ACCW; at most one strobe is high per cycle.
module fact_datapath #(
    parameter int OPW  = 5,
    parameter int CNTW = 4,
    parameter int ACCW = 24,
    parameter int RESW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OPW-1:0]  operand,
    input  logic            load_en,
    input  logic            mul_en,
    input  logic            pub_en,
    output logic            more_steps,
    output logic [RESW-1:0] result
);

    localparam int PRODW = ACCW + CNTW;
    localparam int PADW  = RESW - ACCW;

    logic [CNTW-1:0] cnt_q;
    logic [ACCW-1:0] acc_q;
    logic [RESW-1:0] result_q;
    logic [PRODW-1:0] prod;

    // Full-width product; only its low ACCW bits are kept.
    always_comb begin
        prod = PRODW'(acc_q) * PRODW'(cnt_q);
    end

    // Loop test seen by the controller.
    always_comb begin
        more_steps = (cnt_q > CNTW'(1));
    end

    // Counter and accumulator update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (load_en) begin
            cnt_q <= operand[CNTW-1:0];
            acc_q <= ACCW'(1);
        end else if (mul_en) begin
            cnt_q <= cnt_q - CNTW'(1);
            acc_q <= prod[ACCW-1:0];
        end
    end

    // Result register: written only when publishing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (pub_en) begin
            result_q <= {{PADW{1'b0}}, acc_q};
        end
    end

    assign result = result_q;

    AST_LOAD_SEEDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> acc_q == ACCW'(1));                                      // R3
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        mul_en |=> cnt_q == CNTW'($past(cnt_q) - CNTW'(1)));                 // R3
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pub_en |=> $stable(result_q));                                      // R7

endmodule

// File: rtl/fact_unit.sv
// Module: fact_unit (top)
// Purpose: iterative factorial with a req/ack handshake; one multiply per
//          inner loop pass, one acknowledge pulse per computation.
// Assumes: rst_n synchronous active low and doubles as the run enable.
module fact_unit #(
    parameter int OPW  = 5,
    parameter int CNTW = 4,
    parameter int ACCW = 24,
    parameter int RESW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [OPW-1:0]  operand,
    output logic            ack,
    output logic [RESW-1:0] result
);

    logic load_en;
    logic mul_en;
    logic pub_en;
    logic more_steps;

    fact_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .more_steps (more_steps),
        .load_en    (load_en),
        .mul_en     (mul_en),
        .pub_en     (pub_en),
        .ack        (ack)
    );

    fact_datapath #(
        .OPW  (OPW),
        .CNTW (CNTW),
        .ACCW (ACCW),
        .RESW (RESW)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .operand    (operand),
        .load_en    (load_en),
        .mul_en     (mul_en),
        .pub_en     (pub_en),
        .more_steps (more_steps),
        .result     (result)
    );

    AST_ACK_AFTER_PUBLISH: assert property (@(posedge clk) disable iff (!rst_n)
        pub_en |=> ##1 ack);                                                 // R5

endmodule

// File: tb/fact_unit_test.sv
// Bench for fact_unit: a vector table walked by one loop, then directed
// tests for reset, request stalls, operand bit 4 and wrapping operands.
module fact_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [4:0]  operand = '0;
    logic        ack;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    logic [31:0] prev_res = '0;

    always #2 clk = ~clk;   // 250 MHz

    fact_unit uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .operand (operand),
        .ack     (ack),
        .result  (result)
    );

    // Table: {operand[4:0], expected result[31:0]}.
    localparam int NV = 14;
    localparam logic [36:0] VEC [NV] = '{
        {5'd0,  32'd1},       {5'd1,  32'd1},
        {5'd2,  32'd2},       {5'd3,  32'd6},
        {5'd4,  32'd24},      {5'd5,  32'd120},
        {5'd6,  32'd720},     {5'd7,  32'd5040},
        {5'd8,  32'd40320},   {5'd9,  32'd362880},
        {5'd10, 32'd3628800}, {5'd11, 32'd6362368},
        {5'd16, 32'd1},       {5'd21, 32'd120}
    };

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [4:0] op);
        logic [23:0] acc = 24'd1;
        for (int i = int'(op[3:0]); i > 1; i--) acc = 24'(acc * 24'(i));
        return {8'd0, acc};
    endfunction

    function automatic int latency(input logic [4:0] op);
        int k = int'(op[3:0]);
        return (k < 2) ? 5 : 2 * k + 3;
    endfunction

    // One handshake. Called at a negedge with the unit waiting and req low.
    task automatic run_op(input logic [4:0] op, input logic [31:0] exp);
        int n = 0;
        operand = op;
        req = 1'b1;
        while (n < 100) begin
            @(negedge clk);
            n++;
            if (n == 3) check(result == prev_res, "R7 old result held", result, prev_res);
            if (ack) break;
        end
        req = 1'b0;
        check(result == exp, "R3 result", result, exp);
        check(result[31:24] == 8'd0, "R8 upper bits", result[31:24], 0);
        check(n == latency(op), "R5 latency", n, latency(op));
        @(negedge clk);
        check(ack == 1'b0, "R6 ack one cycle", ack, 0);
        prev_res = result;
    endtask

    initial begin
        // R1: reset held with a request present.
        req = 1'b1;
        operand = 5'd5;
        repeat (4) begin
            @(negedge clk);
            check(ack == 1'b0, "R1 ack in reset", ack, 0);
        end
        check(result == 32'd0, "R1 result in reset", result, 0);
        req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R2: request held low, no answer.
        repeat (20) begin
            operand = operand + 5'd3;
            @(negedge clk);
            check(ack == 1'b0, "R2 no ack without req", ack, 0);
        end

        // Main table, covering R3 and R4.
        for (int i = 0; i < NV; i++) run_op(VEC[i][36:32], VEC[i][31:0]);

        // R4: small operands give 1 in five cycles.
        run_op(5'd1, 32'd1);
        run_op(5'd0, 32'd1);

        // R3: wrapping operands, checked against the model.
        for (int op = 12; op < 16; op++) run_op(5'(op), model(5'(op)));

        // R9: bit 4 does not change result or latency.
        run_op(5'd31, model(5'd15));
        run_op(5'd18, 32'd2);

        // R7: result stable over idle cycles.
        repeat (10) @(negedge clk);
        check(result == prev_res, "R7 idle hold", result, prev_res);

        // R1: reset in mid computation clears the outputs.
        operand = 5'd15;
        req = 1'b1;
        repeat (8) @(negedge clk);
        req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(ack == 1'b0, "R1 mid reset ack", ack, 0);
        check(result == 32'd0, "R1 mid reset result", result, 0);
        rst_n = 1'b1;
        prev_res = '0;
        @(negedge clk);
        run_op(5'd4, 32'd24);

        finish_run();
    end

endmodule